// File: doc/BRIEF.md
# I/O Channel Trap Controller

This block gathers special-condition events from a set of I/O channels and, when software has armed it, takes over the processor for a short trap sequence. Each channel reports three kinds of condition: a control-word completion with no load-channel command waiting, a redundancy (parity) check, and an end-of-file. A condition is latched as pending the moment it is seen. It becomes eligible only when the matching bit of the current enable mask is set. An enable instruction replaces the whole mask and also arms the controller. A restore instruction re-arms it without changing the mask.

When an instruction boundary arrives, the controller may start a trap. It needs to be armed, to have at least one eligible condition, to see no higher-priority floating-point or interrupt request, and to find that the current instruction is not of a deferring class. The trap first issues a memory store command to the channel's even trap word. That store carries PC minus one for the address field and the identifying condition bits for the decrement field, and writes no other field. It then issues a forced instruction fetch from the odd word that follows. Starting a trap disarms the controller, so no further trap can start until an enable or restore instruction executes.

The store command and the fetch command are each a valid/ready stream. Once valid is raised, it stays high and the payload holds steady until ready is seen at a clock edge. Valid never depends on ready in the same cycle. All other pins are plain levels or single-cycle strobes.

Top module: `ctrap_ctrl`

## Requirements
- R1: A condition event that arrives while its enable bit is clear stays pending for any number of cycles, and it traps once an enable instruction sets that bit and an instruction boundary follows.
- R2: An enable strobe replaces the entire mask with `enb_mask` (bit 3*c+k: channel c, k=0 control word, k=1 parity, k=2 end-of-file). A pending condition whose bit is not in the new mask cannot trap.
- R3: Starting a trap disarms the controller. No new trap starts until an enable or restore strobe re-arms it. Reset leaves the controller disarmed.
- R4: `instr_step` with `instr_class` 1 (read select), 2 (write select), 3 (enable), 4 (execute) or 5 (restore) never starts a trap. Classes 0, 6 and 7 may start one.
- R5: While `hp_req` is high, an instruction boundary starts no trap, and the eligible conditions stay pending.
- R6: When several channels are eligible, the lowest-numbered channel is served. The conditions of the other channels stay pending and are served by later traps.
- R7: The store command addresses the even word TRAP_BASE + 2*channel. Its address field is the sampled PC minus one, modulo 2^AW. Its decrement field holds the served channel's eligible conditions in bits [2:0], with the same k order as R2, and zeros above them.
- R8: The fetch command follows the accepted store and addresses the even word plus one. Both commands hold valid and payload steady until they are accepted.
- R9: `trap_req` and `store_valid` rise in the cycle after the boundary that starts a trap. `trap_req` stays high until the cycle after the one that follows the fetch handshake.
- R10: A clear bit removes a pending condition. An event on the same bit in the same cycle wins over the clear.
- R11: After a synchronous reset, no trap is requested and no store or fetch is valid. All pending and enable bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev | input | 3*NUM_CH | Condition event pulses, bit 3*c+k |
| clr | input | 3*NUM_CH | Pending-condition clear pulses |
| enb_stb | input | 1 | Enable instruction strobe |
| enb_mask | input | 3*NUM_CH | New enable mask carried by the enable strobe |
| rct_stb | input | 1 | Restore instruction strobe |
| instr_step | input | 1 | Instruction boundary strobe |
| instr_class | input | 3 | Class of the instruction at this boundary |
| pc | input | AW | Current program counter |
| hp_req | input | 1 | Higher-priority trap or interrupt request |
| trap_req | output | 1 | Trap sequence in progress |
| store_valid | output | 1 | Store command valid |
| store_ready | input | 1 | Store command accepted |
| store_addr | output | AW | Even trap word address |
| store_addr_fld | output | AW | Address-field data (PC minus one) |
| store_dec_fld | output | AW | Decrement-field data (condition bits) |
| fetch_valid | output | 1 | Forced fetch valid |
| fetch_ready | input | 1 | Forced fetch accepted |
| fetch_addr | output | AW | Odd trap word address |

## Verification
Strobes, events and clears act on the rising edge on which they are sampled, so an instruction boundary in the very next cycle already sees the new pending, mask and armed state. A boundary that starts a trap shows `trap_req` and `store_valid` one cycle later. The fetch shows one cycle after the store handshake, and `trap_req` drops two cycles after the fetch handshake. The bench drives every input just after a falling edge and steps a reference model on the rising edge. It compares all outputs at the next falling edge, so each expected value is taken in exactly the cycle in which the register chain above makes it due.

// File: rtl/ctrap_pkg.sv
package ctrap_pkg;

  localparam int COND_N = 3;

  typedef enum logic [2:0] {
    CLS_PLAIN     = 3'd0,
    CLS_READ_SEL  = 3'd1,
    CLS_WRITE_SEL = 3'd2,
    CLS_ENABLE    = 3'd3,
    CLS_EXEC      = 3'd4,
    CLS_RESTORE   = 3'd5,
    CLS_XFER      = 3'd6,
    CLS_SPARE     = 3'd7
  } instr_cls_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_STORE = 2'd1,
    SQ_FETCH = 2'd2,
    SQ_DONE  = 2'd3
  } seq_state_e;

  // Instruction classes that hold a trap off until the next boundary.
  function automatic logic cls_defers(input logic [2:0] c);
    case (instr_cls_e'(c))
      CLS_READ_SEL, CLS_WRITE_SEL, CLS_ENABLE, CLS_EXEC, CLS_RESTORE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ctrap_pending.sv
module ctrap_pending
  import ctrap_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int NB = COND_N * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NB-1:0]     ev,
  input  logic [NB-1:0]     clr,
  input  logic              enb_stb,
  input  logic [NB-1:0]     enb_mask,
  input  logic [NUM_CH-1:0] svc_oh,
  output logic [NB-1:0]     elig
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [COND_N-1:0] pend_q;
    logic [COND_N-1:0] en_q;
    logic [COND_N-1:0] ch_elig;
    logic [COND_N-1:0] svc;

    assign ch_elig = pend_q & en_q;
    assign svc     = svc_oh[c] ? ch_elig : '0;
    assign elig[c*COND_N +: COND_N] = ch_elig;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= '0;
        en_q   <= '0;
      end else begin
        // served and cleared bits drop; a fresh event always lands
        pend_q <= (pend_q & ~svc & ~clr[c*COND_N +: COND_N]) | ev[c*COND_N +: COND_N];
        if (enb_stb) en_q <= enb_mask[c*COND_N +: COND_N];
      end
    end
  end

endmodule

// File: rtl/ctrap_arbiter.sv
module ctrap_arbiter
  import ctrap_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int NB = COND_N * NUM_CH,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NB-1:0]     elig,
  output logic              any,
  output logic [NUM_CH-1:0] sel_oh,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [COND_N-1:0] sel_cond
);

  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] lower;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pri
    assign hit[c] = |elig[c*COND_N +: COND_N];
    if (c == 0) begin : g_first
      assign lower[c] = 1'b0;
    end else begin : g_rest
      assign lower[c] = lower[c-1] | hit[c-1];
    end
    assign sel_oh[c] = hit[c] & ~lower[c];
  end

  assign any = |hit;

  always_comb begin
    sel_idx  = '0;
    sel_cond = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_oh[c]) begin
        sel_idx  = IDX_W'(c);
        sel_cond = elig[c*COND_N +: COND_N];
      end
    end
  end

endmodule

// File: rtl/ctrap_seq.sv
module ctrap_seq
  import ctrap_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int AW = 15,
  parameter int TRAP_BASE = 10,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_step,
  input  logic [2:0]        instr_class,
  input  logic              hp_req,
  input  logic              enb_stb,
  input  logic              rct_stb,
  input  logic [AW-1:0]     pc,
  input  logic              any,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [COND_N-1:0] sel_cond,
  input  logic              store_ready,
  input  logic              fetch_ready,
  output logic              take,
  output logic              trap_req,
  output logic              store_valid,
  output logic [AW-1:0]     store_addr,
  output logic [AW-1:0]     store_addr_fld,
  output logic [AW-1:0]     store_dec_fld,
  output logic              fetch_valid,
  output logic [AW-1:0]     fetch_addr
);

  seq_state_e        state_q;
  logic              arm_q;
  logic [IDX_W-1:0]  cap_idx;
  logic [AW-1:0]     cap_pc;
  logic [COND_N-1:0] cap_cond;
  logic              step_ok;
  logic [AW-1:0]     even_addr;

  assign step_ok = instr_step && !cls_defers(instr_class) && !hp_req;
  assign take    = (state_q == SQ_IDLE) && step_ok && arm_q && any;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      arm_q    <= 1'b0;
      cap_idx  <= '0;
      cap_pc   <= '0;
      cap_cond <= '0;
    end else begin
      arm_q <= (arm_q & ~take) | enb_stb | rct_stb;
      if (take) begin
        cap_idx  <= sel_idx;
        cap_pc   <= pc - AW'(1);
        cap_cond <= sel_cond;
      end
      case (state_q)
        SQ_IDLE:  if (take) state_q <= SQ_STORE;
        SQ_STORE: if (store_ready) state_q <= SQ_FETCH;
        SQ_FETCH: if (fetch_ready) state_q <= SQ_DONE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  assign even_addr      = AW'(TRAP_BASE) + AW'({cap_idx, 1'b0});
  assign trap_req       = (state_q != SQ_IDLE);
  assign store_valid    = (state_q == SQ_STORE);
  assign fetch_valid    = (state_q == SQ_FETCH);
  assign store_addr     = even_addr;
  assign fetch_addr     = even_addr | AW'(1);
  assign store_addr_fld = cap_pc;
  assign store_dec_fld  = AW'(cap_cond);

endmodule

// File: rtl/ctrap_ctrl.sv
module ctrap_ctrl
  import ctrap_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int AW = 15,
  parameter int TRAP_BASE = 10,
  localparam int NB = COND_N * NUM_CH,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] ev,
  input  logic [NB-1:0] clr,
  input  logic          enb_stb,
  input  logic [NB-1:0] enb_mask,
  input  logic          rct_stb,
  input  logic          instr_step,
  input  logic [2:0]    instr_class,
  input  logic [AW-1:0] pc,
  input  logic          hp_req,
  output logic          trap_req,
  output logic          store_valid,
  input  logic          store_ready,
  output logic [AW-1:0] store_addr,
  output logic [AW-1:0] store_addr_fld,
  output logic [AW-1:0] store_dec_fld,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  output logic [AW-1:0] fetch_addr
);

  logic [NB-1:0]     elig;
  logic              any;
  logic [NUM_CH-1:0] sel_oh;
  logic [IDX_W-1:0]  sel_idx;
  logic [COND_N-1:0] sel_cond;
  logic              take;
  logic [NUM_CH-1:0] svc_oh;

  assign svc_oh = take ? sel_oh : '0;

  ctrap_pending #(.NUM_CH(NUM_CH)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .clr      (clr),
    .enb_stb  (enb_stb),
    .enb_mask (enb_mask),
    .svc_oh   (svc_oh),
    .elig     (elig)
  );

  ctrap_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .elig     (elig),
    .any      (any),
    .sel_oh   (sel_oh),
    .sel_idx  (sel_idx),
    .sel_cond (sel_cond)
  );

  ctrap_seq #(.NUM_CH(NUM_CH), .AW(AW), .TRAP_BASE(TRAP_BASE)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .instr_step     (instr_step),
    .instr_class    (instr_class),
    .hp_req         (hp_req),
    .enb_stb        (enb_stb),
    .rct_stb        (rct_stb),
    .pc             (pc),
    .any            (any),
    .sel_idx        (sel_idx),
    .sel_cond       (sel_cond),
    .store_ready    (store_ready),
    .fetch_ready    (fetch_ready),
    .take           (take),
    .trap_req       (trap_req),
    .store_valid    (store_valid),
    .store_addr     (store_addr),
    .store_addr_fld (store_addr_fld),
    .store_dec_fld  (store_dec_fld),
    .fetch_valid    (fetch_valid),
    .fetch_addr     (fetch_addr)
  );

endmodule

// File: rtl/ctrap_ctrl_chk.sv
module ctrap_ctrl_chk
  import ctrap_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int AW = 15,
  localparam int NB = COND_N * NUM_CH
) (
  input logic          clk,
  input logic          rst,
  input logic [NB-1:0] ev,
  input logic [NB-1:0] clr,
  input logic          enb_stb,
  input logic [NB-1:0] enb_mask,
  input logic          rct_stb,
  input logic          instr_step,
  input logic [2:0]    instr_class,
  input logic [AW-1:0] pc,
  input logic          hp_req,
  input logic          trap_req,
  input logic          store_valid,
  input logic          store_ready,
  input logic [AW-1:0] store_addr,
  input logic [AW-1:0] store_addr_fld,
  input logic [AW-1:0] store_dec_fld,
  input logic          fetch_valid,
  input logic          fetch_ready,
  input logic [AW-1:0] fetch_addr
);

  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (!trap_req && !store_valid && !fetch_valid));

  p_defer_r4: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && instr_step && cls_defers(instr_class)) |=> !trap_req);

  p_hp_block_r5: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && hp_req) |=> !trap_req);

  p_no_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && !instr_step) |=> !trap_req);

  p_store_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (store_valid && !store_ready) |=>
      (store_valid && $stable(store_addr) && $stable(store_addr_fld) && $stable(store_dec_fld)));

  p_fetch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

  p_fetch_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (store_valid && store_ready) |=> (fetch_valid && fetch_addr == $past(store_addr) + AW'(1)));

  p_even_word_r7: assert property (@(posedge clk) disable iff (rst)
    store_valid |-> !store_addr[0]);

  p_cmd_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(store_valid && fetch_valid) && ((store_valid || fetch_valid) -> trap_req));

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_ready) |=> (trap_req && !fetch_valid) ##1 !trap_req);

endmodule

bind ctrap_ctrl ctrap_ctrl_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (.*);

// File: tb/ctrap_ctrl_test.sv
module ctrap_ctrl_test;

  localparam int NUM_CH = 3;
  localparam int AW = 15;
  localparam int BASE = 10;
  localparam int NB = 3 * NUM_CH;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] ev = '0, clr = '0, enb_mask = '0;
  logic          enb_stb = 1'b0, rct_stb = 1'b0, instr_step = 1'b0, hp_req = 1'b0;
  logic [2:0]    instr_class = '0;
  logic [AW-1:0] pc = '0;
  logic          store_ready = 1'b1, fetch_ready = 1'b1;
  logic          trap_req, store_valid, fetch_valid;
  logic [AW-1:0] store_addr, store_addr_fld, store_dec_fld, fetch_addr;

  always #2.5 clk = ~clk;

  ctrap_ctrl #(.NUM_CH(NUM_CH), .AW(AW), .TRAP_BASE(BASE)) uut (.*);

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R9";

  // reference model state
  logic [NB-1:0] m_pend = '0, m_en = '0;
  logic          m_arm = 1'b0;
  int            m_st = 0, m_ch = 0;
  logic [AW-1:0] m_fld = '0;
  logic [2:0]    m_id = '0;

  function automatic bit defer_cls(input logic [2:0] c);
    return (c >= 3'd1 && c <= 3'd5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [NB-1:0] elig, svc;
    int sel;
    bit take;
    if (rst) begin
      m_pend = '0; m_en = '0; m_arm = 1'b0; m_st = 0;
      return;
    end
    elig = m_pend & m_en;
    sel = -1;
    for (int c = NUM_CH - 1; c >= 0; c--) if (elig[c*3 +: 3] != 3'b0) sel = c;
    take = (m_st == 0) && instr_step && !defer_cls(instr_class) && !hp_req && m_arm && (sel >= 0);
    svc = '0;
    if (take) begin
      svc[sel*3 +: 3] = elig[sel*3 +: 3];
      m_ch = sel; m_fld = pc - AW'(1); m_id = elig[sel*3 +: 3];
    end
    m_pend = (m_pend & ~svc & ~clr) | ev;
    if (enb_stb) m_en = enb_mask;
    m_arm = (m_arm & ~take) | enb_stb | rct_stb;
    case (m_st)
      0: if (take) m_st = 1;
      1: if (store_ready) m_st = 2;
      2: if (fetch_ready) m_st = 3;
      default: m_st = 0;
    endcase
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({cur_tag, " trap_req"}, 32'(trap_req), 32'(m_st != 0));
    chk("R8 store_valid", 32'(store_valid), 32'(m_st == 1));
    chk("R8 fetch_valid", 32'(fetch_valid), 32'(m_st == 2));
    if (m_st == 1) begin
      chk("R7 store_addr", 32'(store_addr), 32'(BASE + 2 * m_ch));
      chk("R7 addr_fld", 32'(store_addr_fld), 32'(m_fld));
      chk("R7 dec_fld", 32'(store_dec_fld), 32'(m_id));
    end
    if (m_st == 2) chk("R8 fetch_addr", 32'(fetch_addr), 32'(BASE + 2 * m_ch + 1));
    ev = '0; clr = '0; enb_stb = 1'b0; rct_stb = 1'b0; instr_step = 1'b0; hp_req = 1'b0;
  endtask

  task automatic step(input logic [2:0] cls, input logic [AW-1:0] p);
    instr_step = 1'b1; instr_class = cls; pc = p;
    tick();
  endtask

  task automatic finish_trap();
    for (int i = 0; i < 3; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    cur_tag = "R11";
    tick(); tick();
    rst = 1'b0;
    chk("R11 trap_req after reset", 32'(trap_req), 0);
    chk("R11 store_valid after reset", 32'(store_valid), 0);
    chk("R11 fetch_valid after reset", 32'(fetch_valid), 0);

    // R1: event while disabled stays pending
    cur_tag = "R1";
    ev[0] = 1'b1; tick();
    step(3'd0, 15'd50);
    repeat (5) tick();
    chk("R1 no trap while disabled", 32'(trap_req), 0);
    enb_mask = '0; enb_mask[0] = 1'b1; enb_stb = 1'b1; tick();
    step(3'd0, 15'd100);
    chk("R1 trap after enable", 32'(trap_req), 1);
    chk("R7 even word ch0", 32'(store_addr), 32'(BASE));
    chk("R7 pc minus one", 32'(store_addr_fld), 32'd99);
    chk("R7 control-word bit", 32'(store_dec_fld), 32'd1);
    tick();
    chk("R8 odd word ch0", 32'(fetch_addr), 32'(BASE + 1));
    tick();
    chk("R9 still active after fetch", 32'(trap_req), 1);
    tick();
    chk("R9 released", 32'(trap_req), 0);

    // R3: disarmed until restore
    cur_tag = "R3";
    ev[0] = 1'b1; tick();
    step(3'd0, 15'd7);
    chk("R3 no trap while disarmed", 32'(trap_req), 0);
    rct_stb = 1'b1; tick();
    step(3'd6, 15'd7);
    chk("R3 trap after restore", 32'(trap_req), 1);
    finish_trap();

    // R4: deferring classes
    cur_tag = "R4";
    ev[0] = 1'b1; rct_stb = 1'b1; tick();
    for (int c = 1; c <= 5; c++) begin
      step(3'(c), 15'd20);
      chk("R4 deferring class", 32'(trap_req), 0);
    end
    step(3'd7, 15'd20);
    chk("R4 trap at plain class", 32'(trap_req), 1);
    finish_trap();

    // R5: higher-priority request
    cur_tag = "R5";
    ev[0] = 1'b1; rct_stb = 1'b1; tick();
    hp_req = 1'b1; step(3'd0, 15'd30);
    chk("R5 held by higher priority", 32'(trap_req), 0);
    step(3'd0, 15'd30);
    chk("R5 served after", 32'(trap_req), 1);
    finish_trap();

    // R6: lowest channel first, others stay pending
    cur_tag = "R6";
    enb_mask = '1; enb_stb = 1'b1; ev[4] = 1'b1; ev[8] = 1'b1; tick();
    step(3'd0, 15'd40);
    chk("R6 ch1 first", 32'(store_addr), 32'(BASE + 2));
    chk("R6 parity bit", 32'(store_dec_fld), 32'd2);
    finish_trap();
    rct_stb = 1'b1; tick();
    step(3'd0, 15'd41);
    chk("R6 ch2 next", 32'(store_addr), 32'(BASE + 4));
    chk("R6 end-of-file bit", 32'(store_dec_fld), 32'd4);
    finish_trap();

    // R2: enable replaces the mask
    cur_tag = "R2";
    enb_mask = '0; enb_mask[0] = 1'b1; enb_stb = 1'b1; ev[1] = 1'b1; tick();
    step(3'd0, 15'd60);
    chk("R2 parity not enabled", 32'(trap_req), 0);
    enb_mask = '0; enb_mask[1] = 1'b1; enb_stb = 1'b1; tick();
    step(3'd0, 15'd60);
    chk("R2 new mask traps", 32'(trap_req), 1);
    chk("R2 dec bits", 32'(store_dec_fld), 32'd2);
    finish_trap();

    // R10: clear, and event beats clear
    cur_tag = "R10";
    enb_mask = '1; enb_stb = 1'b1; ev[0] = 1'b1; tick();
    clr[0] = 1'b1; tick();
    step(3'd0, 15'd70);
    chk("R10 cleared condition", 32'(trap_req), 0);
    ev[0] = 1'b1; clr[0] = 1'b1; tick();
    step(3'd0, 15'd70);
    chk("R10 event wins", 32'(trap_req), 1);
    finish_trap();

    // R8 back-pressure and R7 wrap of PC minus one
    cur_tag = "R8";
    store_ready = 1'b0; fetch_ready = 1'b0;
    ev[6] = 1'b1; rct_stb = 1'b1; tick();
    step(3'd0, 15'd0);
    for (int i = 0; i < 3; i++) begin
      chk("R8 store held", 32'(store_valid), 1);
      tick();
    end
    chk("R7 wrapped field", 32'(store_addr_fld), 32'h7FFF);
    store_ready = 1'b1; tick();
    store_ready = 1'b0;
    tick(); tick();
    chk("R8 fetch held", 32'(fetch_valid), 1);
    chk("R8 fetch ch2", 32'(fetch_addr), 32'(BASE + 5));
    fetch_ready = 1'b1;
    finish_trap();

    // constrained random
    cur_tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) ev = NB'(1) << ($urandom % NB);
      if ($urandom % 12 == 0) clr = NB'(1) << ($urandom % NB);
      if ($urandom % 16 == 0) begin enb_stb = 1'b1; enb_mask = NB'($urandom); end
      if ($urandom % 10 == 0) rct_stb = 1'b1;
      hp_req = ($urandom % 5 == 0);
      instr_step = ($urandom % 2 == 0);
      instr_class = 3'($urandom);
      pc = AW'($urandom);
      store_ready = ($urandom % 2 == 0);
      fetch_ready = ($urandom % 2 == 0);
      tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule